// File: doc/BRIEF.md
# FIFO-Buffered Serial Port with Register Interface

This block is a memory-mapped serial port. A processor writes bytes into a 16-entry transmit queue and reads received bytes from a 16-entry receive queue. Both transfers go through one data register. A status register reports the level of each queue and holds sticky error bits. A control register enables the receiver and the transmitter separately. A 12-bit scaler sets the bit rate, and a debug register shows both queue occupancies at once.

On the line side the block sends and receives 8N1 frames: one low start bit, eight data bits least significant first, and one high stop bit. A bit lasts eight scaler ticks. A tick occurs once every scaler+1 clock cycles. The receiver samples each bit at the middle of its tick period. A stop bit that reads low is flagged as a framing error.

Top module: `uart_fifo_regs`

## Requirements
- R1: Each queue holds at most 16 bytes and delivers them in the order they were written, including across pointer wrap-around.
- R2: After reset, status reads 0x6 (bit 2 transmit-queue-empty and bit 1 transmit-shifter-empty set), control reads 0, the scaler reads 21 and the debug register reads 0.
- R3: The scaler register (offset 0xC) keeps only bits [11:0] of a write. The bit period is 8*(scaler+1) clock cycles.
- R4: A write to the data register (offset 0x0) with fewer than 16 bytes queued enqueues bits [7:0] and clears status bits 1 and 2. Status bit 7 (transmit half) is set at 8 or more bytes and bit 9 (transmit full) at 16. A write while 16 are queued is dropped and sets overrun, status bit 4.
- R5: A received frame is enqueued only when control bit 0 (receive enable) is 1 and the queue is not full. Status bit 0 (data ready) shows a non-empty queue, bit 8 shows 8 or more entries, and bit 10 shows 16 entries.
- R6: A read of the data register returns the oldest received byte and removes it. Status bits 0, 8 and 10 then follow the new count. A read while the queue is empty returns 0 and changes nothing.
- R7: A write to status (offset 0x4) clears only those of bits 3 (break), 4 (overrun), 5 (parity) and 6 (framing) that are written as 1. Every other status bit ignores the write.
- R8: Bytes leave the transmit queue only while control bit 1 (transmit enable) is 1. When the last frame has completed, status bits 1 and 2 read 1 again.
- R9: Status bit 1 stays 0 while a frame is being shifted out, even when the transmit queue is already empty.
- R10: The debug register (offset 0x10) returns the receive count at bits [30:26] and the transmit count at bits [24:20]. All other bits read 0.
- R11: The line output idles high and sends 8N1 frames. The receiver starts on a falling edge. A frame whose stop bit samples low sets status bit 6 and is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational during the access cycle |
| tx_line | output | 1 | Serial output, idle high |
| rx_line | input | 1 | Serial input, asynchronous |

## Verification
The hardest state to reach from the ports is a full receive queue while further frames keep arriving. The same applies to the overrun that a full transmit queue produces.

The bench loads sixteen bytes with the transmitter disabled and then pushes a seventeenth to force overrun. It then enables both directions with the serial output looped back to the input, so the receive queue fills exactly. One more byte is then sent so that its frame arrives with no room left.

Framing errors come from a bench-driven serial frame with a low stop bit. A sweep loops back all 256 byte values.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
   localparam logic [4:0] OFS_DATA = 5'h00;
   localparam logic [4:0] OFS_STAT = 5'h04;
   localparam logic [4:0] OFS_CTRL = 5'h08;
   localparam logic [4:0] OFS_SCAL = 5'h0C;
   localparam logic [4:0] OFS_DBG  = 5'h10;

   localparam int ST_DR  = 0;
   localparam int ST_TS  = 1;
   localparam int ST_TE  = 2;
   localparam int ST_BR  = 3;
   localparam int ST_OV  = 4;
   localparam int ST_PE  = 5;
   localparam int ST_FE  = 6;
   localparam int ST_TH  = 7;
   localparam int ST_RH  = 8;
   localparam int ST_TF  = 9;
   localparam int ST_RF  = 10;
   localparam int ST_W   = 11;

   localparam int DBG_RX_LSB = 26;
   localparam int DBG_TX_LSB = 20;
endpackage

// File: rtl/uart_fifo_buf.sv
module uart_fifo_buf #(
   parameter int W     = 8,
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  wdata,
   input  logic          pop,
   output logic [W-1:0]  rdata,
   output logic [CW-1:0] count
);
   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;

   always_ff @(posedge clk) begin
      if (push) mem[wp] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (push) wp <= wp + 1'b1;
         if (pop)  rp <= rp + 1'b1;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assign rdata = mem[rp];
endmodule

// File: rtl/uart_fifo_tx.sv
module uart_fifo_tx #(
   parameter int DBITS = 8,
   parameter int TPB   = 8,
   localparam int PW   = $clog2(TPB),
   localparam int BW   = $clog2(DBITS + 2)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [DBITS-1:0] din,
   output logic             busy,
   output logic             line
);
   logic [DBITS+1:0] sh;
   logic [PW-1:0]    ph;
   logic [BW-1:0]    bitn;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         sh   <= '1;
         ph   <= '0;
         bitn <= '0;
      end else if (load && !busy) begin
         busy <= 1'b1;
         sh   <= {1'b1, din, 1'b0};
         ph   <= '0;
         bitn <= '0;
      end else if (busy && tick) begin
         if (ph == PW'(TPB - 1)) begin
            ph <= '0;
            sh <= {1'b1, sh[DBITS+1:1]};
            if (bitn == BW'(DBITS + 1)) busy <= 1'b0;
            else                        bitn <= bitn + 1'b1;
         end else begin
            ph <= ph + 1'b1;
         end
      end
   end

   assign line = busy ? sh[0] : 1'b1;
endmodule

// File: rtl/uart_fifo_rx.sv
module uart_fifo_rx #(
   parameter int DBITS = 8,
   parameter int TPB   = 8,
   localparam int PW   = $clog2(TPB),
   localparam int BW   = $clog2(DBITS + 2),
   localparam int MID  = TPB / 2 - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             line_in,
   output logic             got,
   output logic             ferr,
   output logic [DBITS-1:0] dout
);
   logic          s1, s2, s3;
   logic          active;
   logic [PW-1:0] ph;
   logic [BW-1:0] bitn;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1 <= 1'b1; s2 <= 1'b1; s3 <= 1'b1;
         active <= 1'b0;
         ph     <= '0;
         bitn   <= '0;
         dout   <= '0;
         got    <= 1'b0;
         ferr   <= 1'b0;
      end else begin
         s1   <= line_in;
         s2   <= s1;
         s3   <= s2;
         got  <= 1'b0;
         ferr <= 1'b0;
         if (!active) begin
            if (s3 && !s2) begin
               active <= 1'b1;
               ph     <= '0;
               bitn   <= '0;
            end
         end else if (tick) begin
            ph <= (ph == PW'(TPB - 1)) ? '0 : ph + 1'b1;
            if (ph == PW'(MID)) begin
               bitn <= bitn + 1'b1;
               if (bitn == '0) begin
                  if (s2) active <= 1'b0;
               end else if (bitn == BW'(DBITS + 1)) begin
                  active <= 1'b0;
                  got    <= s2;
                  ferr   <= !s2;
               end else begin
                  dout <= {s2, dout[DBITS-1:1]};
               end
            end
         end
      end
   end
endmodule

// File: rtl/uart_fifo_regs.sv
module uart_fifo_regs
   import uart_fifo_pkg::*;
#(
   parameter int DEPTH        = 16,
   parameter int SCALER_W     = 12,
   parameter int SCALER_RESET = 21,
   parameter int TPB          = 8,
   localparam int CW          = $clog2(DEPTH + 1),
   localparam int HALF        = DEPTH / 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_en,
   input  logic        bus_we,
   input  logic [4:0]  bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   output logic        tx_line,
   input  logic        rx_line
);
   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be a power of two");
   end
   if (CW > 6) begin : g_bad_cw
      $error("DEPTH too large for the debug register fields");
   end
   if (SCALER_W > 32 || SCALER_RESET >= (1 << SCALER_W)) begin : g_bad_scaler
      $error("scaler reset does not fit SCALER_W");
   end

   logic [31:0]         ctrl_q;
   logic [SCALER_W-1:0] scaler_q, sc_cnt;
   logic                tick;
   logic                err_ov, err_fe;
   logic [ST_W-1:0]     status;

   logic wr_data, rd_data, wr_stat;
   logic [CW-1:0] tx_cnt, rx_cnt;
   logic [7:0]    tx_head, rx_head, rx_byte;
   logic          tx_busy, tx_load, tx_push, rx_push, rx_pop;
   logic          rx_got, rx_ferr;
   logic          ctrl_rx, ctrl_tx;

   assign ctrl_rx = ctrl_q[0];
   assign ctrl_tx = ctrl_q[1];
   assign wr_data = bus_en && bus_we && bus_addr == OFS_DATA;
   assign rd_data = bus_en && !bus_we && bus_addr == OFS_DATA;
   assign wr_stat = bus_en && bus_we && bus_addr == OFS_STAT;

   assign tx_push = wr_data && tx_cnt != CW'(DEPTH);
   assign tx_load = ctrl_tx && !tx_busy && tx_cnt != '0;
   assign rx_push = rx_got && ctrl_rx && rx_cnt != CW'(DEPTH);
   assign rx_pop  = rd_data && rx_cnt != '0;

   uart_fifo_buf #(.W(8), .DEPTH(DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(bus_wdata[7:0]),
      .pop(tx_load), .rdata(tx_head), .count(tx_cnt));

   uart_fifo_buf #(.W(8), .DEPTH(DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_byte),
      .pop(rx_pop), .rdata(rx_head), .count(rx_cnt));

   uart_fifo_tx #(.DBITS(8), .TPB(TPB)) u_tx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .load(tx_load), .din(tx_head),
      .busy(tx_busy), .line(tx_line));

   uart_fifo_rx #(.DBITS(8), .TPB(TPB)) u_rx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .line_in(rx_line),
      .got(rx_got), .ferr(rx_ferr), .dout(rx_byte));

   assign tick = sc_cnt == '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         scaler_q <= SCALER_W'(SCALER_RESET);
         sc_cnt   <= SCALER_W'(SCALER_RESET);
         err_ov   <= 1'b0;
         err_fe   <= 1'b0;
      end else begin
         sc_cnt <= tick ? scaler_q : sc_cnt - 1'b1;
         if (bus_en && bus_we && bus_addr == OFS_CTRL) ctrl_q <= bus_wdata;
         if (bus_en && bus_we && bus_addr == OFS_SCAL) scaler_q <= bus_wdata[SCALER_W-1:0];
         if (wr_data && !tx_push)           err_ov <= 1'b1;
         else if (wr_stat && bus_wdata[ST_OV]) err_ov <= 1'b0;
         if (rx_ferr)                       err_fe <= 1'b1;
         else if (wr_stat && bus_wdata[ST_FE]) err_fe <= 1'b0;
      end
   end

   always_comb begin
      status        = '0;
      status[ST_DR] = rx_cnt != '0;
      status[ST_TE] = tx_cnt == '0;
      status[ST_TS] = tx_cnt == '0 && !tx_busy;
      status[ST_BR] = 1'b0;
      status[ST_PE] = 1'b0;
      status[ST_OV] = err_ov;
      status[ST_FE] = err_fe;
      status[ST_TH] = tx_cnt >= CW'(HALF);
      status[ST_RH] = rx_cnt >= CW'(HALF);
      status[ST_TF] = tx_cnt == CW'(DEPTH);
      status[ST_RF] = rx_cnt == CW'(DEPTH);
   end

   always_comb begin
      case (bus_addr)
         OFS_DATA: bus_rdata = (rx_cnt != '0) ? {24'b0, rx_head} : '0;
         OFS_STAT: bus_rdata = 32'(status);
         OFS_CTRL: bus_rdata = ctrl_q;
         OFS_SCAL: bus_rdata = 32'(scaler_q);
         OFS_DBG:  bus_rdata = (32'(rx_cnt) << DBG_RX_LSB) | (32'(tx_cnt) << DBG_TX_LSB);
         default:  bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/uart_fifo_regs_chk.sv
module uart_fifo_regs_chk
   import uart_fifo_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int CW    = 5,
   parameter int SW    = 12
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_en,
   input logic          bus_we,
   input logic [4:0]    bus_addr,
   input logic [31:0]   bus_wdata,
   input logic [CW-1:0] tx_cnt,
   input logic [CW-1:0] rx_cnt,
   input logic          tx_busy,
   input logic          ctrl_rx,
   input logic          rx_got,
   input logic [ST_W-1:0] status,
   input logic [SW-1:0] scaler_q
);
   logic wr_d, rd_d, wr_s, wr_c;
   assign wr_d = bus_en && bus_we && bus_addr == OFS_DATA;
   assign rd_d = bus_en && !bus_we && bus_addr == OFS_DATA;
   assign wr_s = bus_en && bus_we && bus_addr == OFS_STAT;
   assign wr_c = bus_en && bus_we && bus_addr == OFS_SCAL;

   assert_depth_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
      tx_cnt <= CW'(DEPTH) && rx_cnt <= CW'(DEPTH));

   assert_scaler_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_c |=> scaler_q == $past(bus_wdata[SW-1:0]));

   assert_overrun_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_d && tx_cnt == CW'(DEPTH)) |=> status[ST_OV]);

   assert_rx_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_rx |=> rx_cnt <= $past(rx_cnt));

   assert_empty_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_d && rx_cnt == '0 && !rx_got) |=> rx_cnt == '0);

   assert_w1c_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_s && bus_wdata[ST_OV]) |=> !status[ST_OV]);

   assert_w1c_framing_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_s && !bus_wdata[ST_FE] && status[ST_FE]) |=> status[ST_FE]);

   assert_shift_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      tx_busy |-> !status[ST_TS]);
endmodule

bind uart_fifo_regs uart_fifo_regs_chk #(.DEPTH(DEPTH), .CW(CW), .SW(SCALER_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .tx_cnt(tx_cnt),
   .rx_cnt(rx_cnt), .tx_busy(tx_busy), .ctrl_rx(ctrl_rx), .rx_got(rx_got),
   .status(status), .scaler_q(scaler_q));

// File: tb/uart_fifo_regs_test.sv
module uart_fifo_regs_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_en = 1'b0, bus_we = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        tx_line, rx_line;
   logic        loop_on = 1'b0;
   logic        drv_line = 1'b1;
   int          n_chk = 0, n_bad = 0, cyc = 0;

   always #2 clk = ~clk;
   assign rx_line = loop_on ? tx_line : drv_line;

   uart_fifo_regs uut (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tx_line(tx_line), .rx_line(rx_line));

   localparam logic [4:0] A_DATA = 5'h00, A_STAT = 5'h04, A_CTRL = 5'h08,
                          A_SCAL = 5'h0C, A_DBG = 5'h10;

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_en = 1'b0;
   endtask

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wait_tx_idle();
      logic [31:0] s;
      for (int i = 0; i < 3000; i++) begin
         rd(A_STAT, s);
         if (s[1]) break;
      end
      wait_cyc(30);
   endtask

   task automatic drive_frame(input logic [7:0] b, input logic stopb, input int p);
      @(negedge clk);
      drv_line = 1'b0; wait_cyc(p);
      for (int i = 0; i < 8; i++) begin drv_line = b[i]; wait_cyc(p); end
      drv_line = stopb; wait_cyc(p);
      drv_line = 1'b1; wait_cyc(3 * p);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc == 190000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
         end
      end
   end

   initial begin
      logic [31:0] v;
      wait_cyc(4);
      rst_n = 1'b1;
      wait_cyc(2);

      // R2 reset state
      rd(A_STAT, v); check("R2 status", v, 32'h6);
      rd(A_CTRL, v); check("R2 control", v, 32'h0);
      rd(A_SCAL, v); check("R2 scaler", v, 32'd21);
      rd(A_DBG, v);  check("R2 debug", v, 32'h0);

      // R3 scaler width
      wr(A_SCAL, 32'hFFFF_F123);
      rd(A_SCAL, v); check("R3 scaler mask", v, 32'h123);
      wr(A_SCAL, 32'h0);

      // R6 empty read
      rd(A_DATA, v); check("R6 empty read data", v, 32'h0);
      rd(A_STAT, v); check("R6 empty read status", v, 32'h6);

      // R4 transmit fill with transmitter disabled
      for (int i = 0; i < 16; i++) begin
         wr(A_DATA, 32'hFFFF_FF30 + 32'(i));
         rd(A_STAT, v);
         check("R4 tx half", 32'(v[7]), (i >= 7) ? 32'd1 : 32'd0);
         check("R4 tx full", 32'(v[9]), (i == 15) ? 32'd1 : 32'd0);
      end
      rd(A_STAT, v); check("R4 status at 16", v, 32'h280);
      rd(A_DBG, v);  check("R10 debug tx 16", v, 32'd16 << 20);
      wr(A_DATA, 32'hEE);
      rd(A_STAT, v); check("R4 overrun set", v, 32'h290);
      rd(A_DBG, v);  check("R4 dropped write", v, 32'd16 << 20);
      // R8 nothing leaves while disabled
      wait_cyc(200);
      check("R8 line idle", 32'(tx_line), 32'd1);
      rd(A_DBG, v);  check("R8 tx held", v, 32'd16 << 20);
      // R7 write of 0 keeps overrun, write of 1 clears
      wr(A_STAT, 32'h0);
      rd(A_STAT, v); check("R7 zero write keeps", v, 32'h290);
      wr(A_STAT, 32'h10);
      rd(A_STAT, v); check("R7 overrun cleared", v, 32'h280);

      // R1/R5 loopback fills the receive queue exactly
      loop_on = 1'b1;
      wr(A_CTRL, 32'h3);
      wait_tx_idle();
      rd(A_DBG, v);  check("R10 debug rx 16", v, 32'd16 << 26);
      rd(A_STAT, v); check("R5 rx full status", v, 32'h507);
      wr(A_DATA, 32'hEE);
      wait_tx_idle();
      rd(A_DBG, v);  check("R5 rx full drop", v, 32'd16 << 26);
      for (int i = 0; i < 16; i++) begin
         rd(A_DATA, v); check("R1 order", v, 32'h30 + 32'(i));
         rd(A_STAT, v);
         check("R6 rx half", 32'(v[8]), (i < 8) ? 32'd1 : 32'd0);
         check("R6 rx full", 32'(v[10]), 32'd0);
      end
      rd(A_STAT, v); check("R6 drained", v, 32'h6);

      // R9 shifter busy while queue empty
      wr(A_DATA, 32'h5A);
      wait_cyc(3);
      rd(A_STAT, v); check("R9 shifting", v & 32'h6, 32'h4);
      wait_tx_idle();
      rd(A_DATA, v); check("R11 loopback byte", v, 32'h5A);

      // R11 line timing with scaler 2 (bit = 24 cycles), receiver disabled (R5)
      wr(A_SCAL, 32'd2);
      wr(A_CTRL, 32'h2);
      wr(A_DATA, 32'hA5);
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (tx_line == 1'b0) break;
      end
      wait_cyc(12);
      for (int k = 0; k < 10; k++) begin
         logic e;
         e = (k == 0) ? 1'b0 : (k == 9) ? 1'b1 : 8'hA5 >> (k - 1);
         check("R11 frame bit", 32'(tx_line), 32'(e));
         wait_cyc(24);
      end
      wait_cyc(60);
      rd(A_DBG, v);  check("R5 rx disabled count", v, 32'h0);
      rd(A_STAT, v); check("R5 rx disabled status", v, 32'h6);
      rd(A_CTRL, v); check("R8 control readback", v, 32'h2);

      // R11 framing error from driven line, scaler 0 (bit = 8 cycles)
      wr(A_SCAL, 32'd0);
      loop_on = 1'b0;
      wr(A_CTRL, 32'h1);
      drive_frame(8'h81, 1'b0, 8);
      rd(A_DBG, v);  check("R11 bad frame dropped", v, 32'h0);
      wr(A_STAT, 32'h0);
      rd(A_STAT, v); check("R7 framing kept", v, 32'h46);
      drive_frame(8'h3C, 1'b1, 8);
      rd(A_STAT, v); check("R11 good frame", v, 32'h47);
      wr(A_STAT, 32'hFFFF_FFFF);
      rd(A_STAT, v); check("R7 only sticky bits clear", v, 32'h7);
      rd(A_DATA, v); check("R11 driven byte", v, 32'h3C);

      // R1/R11 sweep of all byte values through loopback
      loop_on = 1'b1;
      wr(A_CTRL, 32'h3);
      for (int b = 0; b < 256; b++) begin
         wr(A_DATA, 32'(b));
         for (int t = 0; t < 200; t++) begin
            rd(A_STAT, v);
            if (v[0]) break;
         end
         rd(A_DATA, v); check("R1 sweep", v, 32'(b));
      end
      wait_tx_idle();
      rd(A_STAT, v); check("R8 final idle", v, 32'h6);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule